// File: doc/BRIEF.md
# Backup Power Mode Sequencer

This block is the digital sequencer that moves a powered system between normal operation from its input supply and backup operation from a battery. It watches two flags. The first is a power-fail flag from an input-voltage comparator. The second is a gate-good flag, which reports that the drive on the input pass transistors has reached conduction level. From these it drives the charger enable, the pass-gate discharge, the gate charge-pump enable, the backup boost enable, an input pull-down enable and a power-fail status pin.

When input power is lost, the block drops into backup at once. It then holds backup for a programmable minimum dwell in clock cycles, and during that dwell the power-fail flag is not looked at. Once the dwell is over, it waits for the input to come back and re-arms the pass gate. It hands the load back to the input only when the gate-good flag confirms that the forward path is conducting. Both flags are asynchronous and pass through synchronizer chains before the state machine uses them. Reset is synchronous and active high.

Top module: `bkup_mode_seq`

## Requirements
- R1: While reset is applied and for SYNC_STAGES cycles after it is released, the block holds a start-up state. In that state the gate discharge is on and the charger, charge pump, boost and pull-down are off. The block then enters normal mode if the power-fail input is low, and backup with a fresh dwell if it is high.
- R2: In normal mode the charger enable and the charge-pump enable are 1, and the gate discharge, boost enable and pull-down are 0.
- R3: A power-fail input that rises in normal mode switches the outputs to backup on the third rising clock edge. Backup means charger 0, charge pump 0, gate discharge 1 and boost 1.
- R4: Each entry into backup starts a dwell. During the dwell, the input pull-down and the boost stay at 1 for exactly DWELL_CYC cycles, whatever the power-fail input does.
- R5: If power is still failed when the dwell ends, the pull-down drops to 0 while the boost and the gate discharge stay at 1.
- R6: When power is present after the dwell, the block enters a restore step. In that step the charge pump is 1, the gate discharge is 0, the boost is still 1 and the charger is 0.
- R7: The restore step ends only on the synchronized gate-good flag. The boost then goes to 0 and the charger to 1. The boost never falls unless gate-good was high on the previous edge.
- R8: A power failure during the restore step re-enters backup with the gate discharged. It also restarts a full DWELL_CYC pull-down dwell.
- R9: The power-fail status output pf_pull_o follows the power-fail input two clock edges later in every mode, including the dwell. A value of 1 means the pin is pulled low (power absent) and 0 means it is released.
- R10: The charger enable and the boost enable are never 1 together. The charge-pump enable and the gate discharge are never 1 together.
- R11: The gate-good input has no effect in any state other than the restore step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pwr_fail_i | input | 1 | Asynchronous power-fail comparator flag, 1 = input power absent |
| gate_good_i | input | 1 | Asynchronous flag, 1 = pass gate at conduction level |
| chg_en_o | output | 1 | Battery charger enable |
| gate_dis_o | output | 1 | Pass-gate discharge to ground |
| cp_en_o | output | 1 | Gate charge-pump enable |
| boost_en_o | output | 1 | Backup boost converter enable |
| in_pd_o | output | 1 | Input discharge pull-down enable |
| pf_pull_o | output | 1 | Power-fail status, 1 = pin pulled low |

## Verification
The checker evaluates four properties on every cycle: the two exclusion rules, the requirement that the boost is on whenever the pull-down is, and the rule that a boost turn-on always starts with the pull-down. A counter in the checker measures every pull-down window against DWELL_CYC, and every boost turn-off is checked against the gate-good flag seen on the edge before. The bench scenarios are what show the reaction latency, the start-up choice between modes, that power-fail glitches and gate-good are ignored during the dwell and the hold, and the dwell restart after a failure in the restore step.

// File: rtl/bkup_pkg.sv
package bkup_pkg;

    typedef enum logic [2:0] {
        ST_INIT    = 3'd0,
        ST_NORMAL  = 3'd1,
        ST_DWELL   = 3'd2,
        ST_HOLD    = 3'd3,
        ST_RESTORE = 3'd4
    } mode_e;

    typedef struct packed {
        logic chg_en;
        logic gate_dis;
        logic cp_en;
        logic boost_en;
        logic in_pd;
    } ctrl_t;

    function automatic ctrl_t decode_mode(mode_e m);
        ctrl_t c;
        c = '0;
        case (m)
            ST_NORMAL: begin
                c.chg_en = 1'b1;
                c.cp_en  = 1'b1;
            end
            ST_DWELL: begin
                c.gate_dis = 1'b1;
                c.boost_en = 1'b1;
                c.in_pd    = 1'b1;
            end
            ST_HOLD: begin
                c.gate_dis = 1'b1;
                c.boost_en = 1'b1;
            end
            ST_RESTORE: begin
                c.cp_en    = 1'b1;
                c.boost_en = 1'b1;
            end
            default: begin
                c.gate_dis = 1'b1;
            end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/bkup_sync.sv
module bkup_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = din;
        end else begin : g_chain
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{RST_VAL}};
        else     chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/bkup_dwell_timer.sv
module bkup_dwell_timer #(
    parameter int DWELL_CYC = 25_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    localparam int CNT_W = (DWELL_CYC > 1) ? $clog2(DWELL_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DWELL_CYC - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        done  = run && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (!run)      cnt_d = '0;
        else if (!done) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/bkup_fsm.sv
module bkup_fsm
    import bkup_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  pf_s,
    input  logic  gg_s,
    input  logic  tmr_done,
    output logic  tmr_run,
    output ctrl_t ctrl
);
    localparam int INIT_W = $clog2(SYNC_STAGES + 1);
    localparam logic [INIT_W-1:0] INIT_LAST = INIT_W'(SYNC_STAGES);

    typedef struct packed {
        mode_e             mode;
        logic [INIT_W-1:0] init_cnt;
    } fsm_t;

    fsm_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        case (cur_q.mode)
            ST_INIT: begin
                if (cur_q.init_cnt == INIT_LAST)
                    nxt_d.mode = pf_s ? ST_DWELL : ST_NORMAL;
                else
                    nxt_d.init_cnt = cur_q.init_cnt + 1'b1;
            end
            ST_NORMAL: begin
                if (pf_s) nxt_d.mode = ST_DWELL;
            end
            ST_DWELL: begin
                if (tmr_done) nxt_d.mode = pf_s ? ST_HOLD : ST_RESTORE;
            end
            ST_HOLD: begin
                if (!pf_s) nxt_d.mode = ST_RESTORE;
            end
            ST_RESTORE: begin
                if (pf_s)      nxt_d.mode = ST_DWELL;
                else if (gg_s) nxt_d.mode = ST_NORMAL;
            end
            default: nxt_d.mode = ST_INIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q.mode     <= ST_INIT;
            cur_q.init_cnt <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign tmr_run = (cur_q.mode == ST_DWELL);
    assign ctrl    = decode_mode(cur_q.mode);
endmodule

// File: rtl/bkup_mode_seq.sv
module bkup_mode_seq
    import bkup_pkg::*;
#(
    parameter int DWELL_CYC   = 25_000_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_fail_i,
    input  logic gate_good_i,
    output logic chg_en_o,
    output logic gate_dis_o,
    output logic cp_en_o,
    output logic boost_en_o,
    output logic in_pd_o,
    output logic pf_pull_o
);
    logic  pf_s, gg_s, tmr_run, tmr_done;
    ctrl_t ctrl;

    bkup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pf_sync (
        .clk(clk), .rst(rst), .din(pwr_fail_i), .dout(pf_s)
    );

    bkup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_gg_sync (
        .clk(clk), .rst(rst), .din(gate_good_i), .dout(gg_s)
    );

    bkup_dwell_timer #(.DWELL_CYC(DWELL_CYC)) u_timer (
        .clk(clk), .rst(rst), .run(tmr_run), .done(tmr_done)
    );

    bkup_fsm #(.SYNC_STAGES(SYNC_STAGES)) u_fsm (
        .clk(clk), .rst(rst), .pf_s(pf_s), .gg_s(gg_s),
        .tmr_done(tmr_done), .tmr_run(tmr_run), .ctrl(ctrl)
    );

    assign chg_en_o   = ctrl.chg_en;
    assign gate_dis_o = ctrl.gate_dis;
    assign cp_en_o    = ctrl.cp_en;
    assign boost_en_o = ctrl.boost_en;
    assign in_pd_o    = ctrl.in_pd;
    assign pf_pull_o  = pf_s;
endmodule

// File: rtl/bkup_seq_chk.sv
module bkup_seq_chk #(
    parameter int DWELL_CYC = 25_000_000
) (
    input logic clk,
    input logic rst,
    input logic chg_en_o,
    input logic gate_dis_o,
    input logic cp_en_o,
    input logic boost_en_o,
    input logic in_pd_o,
    input logic gg_s
);
    localparam int PD_W = $clog2(DWELL_CYC + 2);
    logic [PD_W-1:0] pd_cnt_q;

    always_ff @(posedge clk) begin
        if (rst)          pd_cnt_q <= '0;
        else if (in_pd_o) pd_cnt_q <= pd_cnt_q + 1'b1;
        else              pd_cnt_q <= '0;
    end

    p_chg_boost_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(chg_en_o && boost_en_o));

    p_cp_dis_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(cp_en_o && gate_dis_o));

    p_pd_needs_boost_r4: assert property (@(posedge clk) disable iff (rst)
        in_pd_o |-> boost_en_o);

    p_entry_dwell_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(boost_en_o) |-> (in_pd_o && gate_dis_o && !chg_en_o));

    p_dwell_len_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(in_pd_o) |-> (pd_cnt_q == PD_W'(DWELL_CYC)));

    p_handover_gg_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(boost_en_o) |-> ($past(gg_s) && chg_en_o));
endmodule

bind bkup_mode_seq bkup_seq_chk #(.DWELL_CYC(DWELL_CYC)) u_chk (
    .clk(clk), .rst(rst), .chg_en_o(chg_en_o), .gate_dis_o(gate_dis_o),
    .cp_en_o(cp_en_o), .boost_en_o(boost_en_o), .in_pd_o(in_pd_o), .gg_s(gg_s)
);

// File: tb/bkup_mode_seq_bench.sv
module bkup_mode_seq_bench;
    localparam int DWELL = 40;
    // output vector order: {chg, gate_dis, cp, boost, in_pd}
    localparam logic [4:0] O_INIT    = 5'b01000;
    localparam logic [4:0] O_NORMAL  = 5'b10100;
    localparam logic [4:0] O_DWELL   = 5'b01011;
    localparam logic [4:0] O_HOLD    = 5'b01010;
    localparam logic [4:0] O_RESTORE = 5'b00110;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pf = 1'b0;
    logic gg = 1'b0;
    logic chg, gdis, cp, boost, pd, pfpull;
    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    bkup_mode_seq #(.DWELL_CYC(DWELL), .SYNC_STAGES(2)) u_bkup_mode_seq (
        .clk(clk), .rst(rst), .pwr_fail_i(pf), .gate_good_i(gg),
        .chg_en_o(chg), .gate_dis_o(gdis), .cp_en_o(cp),
        .boost_en_o(boost), .in_pd_o(pd), .pf_pull_o(pfpull)
    );

    function automatic logic [4:0] outs();
        return {chg, gdis, cp, boost, pd};
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_out(logic [4:0] exp, string tag);
        chk(outs() == exp, tag, int'(outs()), int'(exp));
    endtask

    // counts cycles with pull-down high, starting at a sample where it is high
    task automatic count_pd(output int n, output bit boost_held);
        n = 1;
        boost_held = 1'b1;
        for (int i = 0; i < 4 * DWELL; i++) begin
            tick(1);
            if (!pd) break;
            if (!boost) boost_held = 1'b0;
            n++;
        end
    endtask

    task automatic t_reset(bit pf_at_start);
        rst = 1'b1; pf = pf_at_start; gg = 1'b0;
        tick(3);
        chk_out(O_INIT, "R1 outputs in reset");
        rst = 1'b0;
        tick(2);
        chk_out(O_INIT, "R1 start-up hold");
        tick(1);
        if (pf_at_start) chk_out(O_DWELL, "R1 start into backup");
        else             chk_out(O_NORMAL, "R1/R2 start into normal");
    endtask

    task automatic t_fail_entry();
        pf = 1'b1;
        tick(2);
        chk_out(O_NORMAL, "R3 no early switch");
        chk(pfpull == 1'b1, "R9 status pulled after two edges", pfpull, 1);
        tick(1);
        chk_out(O_DWELL, "R3 backup on third edge");
    endtask

    task automatic t_dwell_hold();
        int n; bit held;
        gg = 1'b1;  // R11: gate-good during dwell and hold must do nothing
        fork
            count_pd(n, held);
            begin tick(5); pf = 1'b0; tick(4); pf = 1'b1; end
        join
        chk(n == DWELL, "R4 pull-down dwell length with glitch", n, DWELL);
        chk(held, "R4 boost held in dwell", held, 1);
        chk_out(O_HOLD, "R5 hold after dwell, R11 gate-good ignored");
        tick(10);
        chk_out(O_HOLD, "R11 hold stays with gate-good high");
        gg = 1'b0;
    endtask

    task automatic t_restore();
        pf = 1'b0;
        tick(2);
        chk(pfpull == 1'b0, "R9 status released", pfpull, 0);
        tick(1);
        chk_out(O_RESTORE, "R6 restore step");
        tick(12);
        chk_out(O_RESTORE, "R7 waits for gate-good");
        gg = 1'b1;
        tick(2);
        chk_out(O_RESTORE, "R7 sync latency");
        tick(1);
        chk_out(O_NORMAL, "R7 handover to normal");
        tick(5);
        chk_out(O_NORMAL, "R11 gate-good in normal no effect");
        gg = 1'b0;
        tick(3);
        chk_out(O_NORMAL, "R2 normal after gate-good drops");
    endtask

    task automatic t_refail();
        int n; bit held;
        pf = 1'b1;
        tick(3);
        chk_out(O_DWELL, "R3 second entry");
        pf = 1'b0;
        count_pd(n, held);
        chk(n == DWELL, "R4 dwell with power back", n, DWELL);
        chk_out(O_RESTORE, "R6 direct restore after dwell");
        pf = 1'b1;
        tick(3);
        chk_out(O_DWELL, "R8 refail re-enters dwell");
        count_pd(n, held);
        chk(n == DWELL, "R8 full dwell restarted", n, DWELL);
        chk_out(O_HOLD, "R5 hold after restarted dwell");
        pf = 1'b0;
        tick(3);
        chk_out(O_RESTORE, "R6 restore again");
        gg = 1'b1;
        tick(3);
        chk_out(O_NORMAL, "R7 normal again");
        gg = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        tick(1);
        t_reset(1'b0);
        t_fail_entry();
        t_dwell_hold();
        t_restore();
        t_refail();
        t_reset(1'b1);
        tick(DWELL + 2);
        chk_out(O_HOLD, "R1/R5 start-up backup goes to hold");
        chk(pfpull == 1'b1, "R9 status while failed", pfpull, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule